// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is the smallest programmable logic element of a reconfigurable fabric. A writable table of eight 2-bit words is addressed directly by three logic inputs, so loading the table lets the cell compute any combinational function of three inputs with two outputs. Reloading the table gives the cell a new function.

Each table output bit has its own flip-flop, clocked by the cell clock on every rising edge, and its own output multiplexer. A programmable select bit sets whether that output shows the raw table value or the registered value. A configuration port writes table words and, through a separate enable, the two select bits. Both kinds of configuration write take effect at the rising clock edge.

Top module: `lut_cell`

## Requirements
- R1: An active-low asynchronous reset clears every table word, both select bits and both flip-flops, so `result` reads 0 for every value of `in_a` after reset.
- R2: When `cfg_lut_we` is 1 at a rising edge, `cfg_data` is stored in the table word at `cfg_addr`. The new word appears on a combinational output from the following cycle onward.
- R3: The table address is `in_a`, used unchanged, with `in_a[0]` as address bit 0. Table word bit i drives `result[i]`.
- R4: A select bit of 0 makes the matching `result` bit follow the table word at `in_a` with no clock delay.
- R5: A select bit of 1 makes the matching `result` bit show the table bit that was sampled at the previous rising edge. An input change between edges does not reach that output.
- R6: When `cfg_sel_we` is 1 at a rising edge, `cfg_data[i]` is loaded into the select bit of output i. Each output keeps its own select bit.
- R7: The flip-flops sample on every edge, whatever the select bits hold. Switching an output to registered therefore shows the value sampled at the most recent edge.
- R8: While `cfg_lut_we` and `cfg_sel_we` are 0, changes on `cfg_addr` and `cfg_data` have no effect. Rewriting a table word changes the function the cell computes.
- R9: With words 0 to 7 loaded as 00,01,01,10,01,10,10,11, the cell acts as a full adder: `result[0]` is the sum and `result[1]` is the carry out of the three inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | 3 | Logic inputs, used as the table address |
| cfg_addr | input | 3 | Table word to write |
| cfg_data | input | 2 | Table word value, or select bits when `cfg_sel_we` is 1 |
| cfg_lut_we | input | 1 | Write enable for the table word |
| cfg_sel_we | input | 1 | Write enable for the two select bits |
| result | output | 2 | The two cell outputs |

## Verification
Several rules are checked on every cycle by the assertions:
- `result` is 0 when reset is released.
- A registered output equals the table bit of the previous edge.
- A select write loads the select bits.
- A written word under the current inputs shows up one cycle later.
- With no write pending and the inputs held, a combinational output stays still.

Only the bench scenarios can show the following:
- The full-adder function across all eight input patterns.
- Correct behaviour when the two outputs use different paths.
- That configuration values presented with both enables low are ignored.
- That a reset in mid-operation wipes a programmed function.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    // Output path choice held in each select bit
    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;
endpackage

// File: rtl/lcell_table.sv
module lcell_table #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_IN-1:0]  wr_addr,
    input  logic [N_OUT-1:0] wr_data,
    input  logic [N_IN-1:0]  rd_addr,
    output logic [N_OUT-1:0] rd_data
);
    localparam int DEPTH = 1 << N_IN;

    typedef struct packed {
        logic [DEPTH-1:0][N_OUT-1:0] word;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.word[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Read port: inputs used directly as the address
    assign rd_data = tbl_q.word[rd_addr];
endmodule

// File: rtl/lcell_modereg.sv
module lcell_modereg #(
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_OUT-1:0] wr_data,
    output logic [N_OUT-1:0] sel
);
    typedef struct packed {
        logic [N_OUT-1:0] sel;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d.sel = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign sel = mode_q.sel;
endmodule

// File: rtl/lcell_outstage.sv
module lcell_outstage
    import lcell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lut_bit,
    input  logic sel,
    output logic out_bit
);
    typedef struct packed {
        logic ff;
    } stage_t;

    stage_t stage_d, stage_q;

    // The flip-flop samples on every edge, whatever the select holds
    always_comb begin
        stage_d    = stage_q;
        stage_d.ff = lut_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    always_comb begin
        if (path_e'(sel) == PATH_REG) begin
            out_bit = stage_q.ff;
        end else begin
            out_bit = lut_bit;
        end
    end
endmodule

// File: rtl/lut_cell.sv
module lut_cell #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_a,
    input  logic [N_IN-1:0]  cfg_addr,
    input  logic [N_OUT-1:0] cfg_data,
    input  logic             cfg_lut_we,
    input  logic             cfg_sel_we,
    output logic [N_OUT-1:0] result
);
    logic [N_OUT-1:0] lut_val;
    logic [N_OUT-1:0] sel_q;

    lcell_table #(.N_IN(N_IN), .N_OUT(N_OUT)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_lut_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_addr (in_a),
        .rd_data (lut_val)
    );

    lcell_modereg #(.N_OUT(N_OUT)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_sel_we),
        .wr_data (cfg_data),
        .sel     (sel_q)
    );

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
        lcell_outstage u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .lut_bit (lut_val[gi]),
            .sel     (sel_q[gi]),
            .out_bit (result[gi])
        );
    end
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IN-1:0]  in_a,
    input logic [N_IN-1:0]  cfg_addr,
    input logic [N_OUT-1:0] cfg_data,
    input logic             cfg_lut_we,
    input logic             cfg_sel_we,
    input logic [N_OUT-1:0] result,
    input logic [N_OUT-1:0] sel_q,
    input logic [N_OUT-1:0] lut_val
);
    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result == '0)); // R1

    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lut_we && !cfg_sel_we && cfg_addr == in_a && sel_q == '0)
        |=> (!$stable(in_a) || result == $past(cfg_data))); // R2

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel_we |=> (sel_q == $past(cfg_data))); // R6

    AST_COMB_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lut_we && !cfg_sel_we && sel_q == '0)
        |=> (!$stable(in_a) || $stable(result))); // R8

    for (genvar gi = 0; gi < N_OUT; gi++) begin : g_bit
        AST_REG_PATH: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[gi] && !cfg_sel_we) |=> (result[gi] == $past(lut_val[gi]))); // R5
    end
endmodule

bind lut_cell lut_cell_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_a       (in_a),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data),
    .cfg_lut_we (cfg_lut_we),
    .cfg_sel_we (cfg_sel_we),
    .result     (result),
    .sel_q      (sel_q),
    .lut_val    (lut_val)
);

// File: tb/lut_cell_test.sv
module lut_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] in_a = '0;
    logic [2:0] cfg_addr = '0;
    logic [1:0] cfg_data = '0;
    logic       cfg_lut_we = 1'b0;
    logic       cfg_sel_we = 1'b0;
    logic [1:0] result;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk; // 125 MHz

    lut_cell uut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .cfg_lut_we(cfg_lut_we),
        .cfg_sel_we(cfg_sel_we), .result(result)
    );

    // {in_a, expected {carry,sum}} for a full adder
    localparam logic [4:0] FA_VEC [8] = '{
        {3'd0, 2'b00}, {3'd1, 2'b01}, {3'd2, 2'b01}, {3'd3, 2'b10},
        {3'd4, 2'b01}, {3'd5, 2'b10}, {3'd6, 2'b10}, {3'd7, 2'b11}
    };

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic wr_word(input logic [2:0] a, input logic [1:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_data = d; cfg_lut_we = 1'b1;
        @(negedge clk);
        cfg_lut_we = 1'b0;
    endtask

    task automatic wr_sel(input logic [1:0] s);
        @(negedge clk);
        cfg_data = s; cfg_sel_we = 1'b1;
        @(negedge clk);
        cfg_sel_we = 1'b0;
    endtask

    function automatic logic [1:0] fa(input logic [2:0] v);
        return 2'(v[0]) + 2'(v[1]) + 2'(v[2]);
    endfunction

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: result=%b expected=done", result);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_a = 3'(i);
            #1 check("R1 reset clear", result, 2'b00);
        end

        // R2 R3 R9: load full adder, walk vectors on the combinational path (R4)
        for (int i = 0; i < 8; i++) wr_word(3'(i), FA_VEC[i][1:0]);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_a = FA_VEC[i][4:2];
            #1 check("R9 full adder", result, FA_VEC[i][1:0]);
            #1 check("R3 address order", result, fa(in_a));
        end

        // R4: combinational path has no clock delay
        @(negedge clk);
        in_a = 3'd0;
        #1 in_a = 3'd7;
        #1 check("R4 no clock delay", result, 2'b11);

        // R5: registered path on both bits
        wr_sel(2'b11);
        in_a = 3'd5;
        @(negedge clk);
        check("R5 registered value", result, fa(3'd5));
        in_a = 3'd0;
        #1 check("R5 input change held", result, fa(3'd5));
        @(negedge clk);
        check("R5 next edge", result, 2'b00);

        // R6: mixed paths, bit0 registered, bit1 combinational
        wr_sel(2'b01);
        in_a = 3'd3;
        @(negedge clk);
        in_a = 3'd4;
        #1 check("R6 mixed paths", result, 2'b00); // carry(4)=0, sum held from 3 =0
        @(negedge clk);
        in_a = 3'd6;
        #1 check("R6 mixed paths b", result, 2'b11); // carry(6)=1, sum from 4 =1

        // R7: flip-flop sampled while combinational, seen right after switch
        wr_sel(2'b00);
        in_a = 3'd7;
        @(negedge clk);
        @(negedge clk);
        cfg_data = 2'b11; cfg_sel_we = 1'b1;
        in_a = 3'd7;
        @(negedge clk);
        cfg_sel_we = 1'b0;
        in_a = 3'd0;
        #1 check("R7 ff sampled before switch", result, 2'b11);
        wr_sel(2'b00);

        // R8: config values with enables low are ignored
        in_a = 3'd2;
        @(negedge clk);
        cfg_addr = 3'd2; cfg_data = 2'b10;
        repeat (2) @(negedge clk);
        check("R8 ignored while disabled", result, 2'b01);
        // R8: rewrite changes the function (R2 visible next cycle)
        wr_word(3'd2, 2'b10);
        #1 check("R8 R2 rewritten word", result, 2'b10);
        in_a = 3'd1;
        #1 check("R8 other word kept", result, 2'b01);

        // R1: reset in mid-operation wipes table and selects
        wr_sel(2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 async clear", result, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            in_a = 3'(i);
            #1 check("R1 table wiped", result, 2'b00);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule